// File: doc/BRIEF.md
# Prioritized DMA Burst Request Arbiter

This block sits between four DMA requesters and a single 32-bit bus master port. Each requester loads a word-aligned start address, a word count and a transfer direction into its own slot. Between bursts the block picks the highest-priority slot that still has words left. It then issues one burst of one to four words. The burst is clipped so that it never runs past the next 16-byte line. Once the burst ends, the slot's address and count are updated, and the next arbitration round begins.

The four slots have fixed ranks. Slot 0 is the receive buffer manager write and ranks highest. Slot 1 is the receive buffer manager read. Slot 2 is the transmit data read. Slot 3 is the receive data write and ranks lowest.

The bus side is a plain request/ready handshake. The block holds `bus_req` high for the whole burst. It presents the current beat address, the direction and the burst length, and it advances one beat on every cycle where `bus_ready` is high.

Top module: `dma_burst_arb`

## Requirements
- R1: While `rst_n` is low, all slots are empty (`pending` = 0), `bus_req` is low and `beat_cnt` is 0.
- R2: A pulse on `ld_en[i]` loads slot i with address `ld_addr[i]` (bits [1:0] dropped), count `ld_cnt[i]` and direction `ld_dir[i]`. The load takes effect only if the slot's remaining count is zero at that edge; otherwise the load is ignored. `pending[i]` is high exactly when slot i has a nonzero remaining count.
- R3: When a new burst starts, the slot granted is the lowest-numbered slot with a nonzero count. Slot 0 ranks highest and slot 3 lowest. `grant_id` gives the slot number as a 2-bit binary value.
- R4: `bus_len` is the smallest of three values: the remaining count, 4, and the number of words up to the next 16-byte boundary (4 minus byte-address bits [3:2]).
- R5: No burst crosses a 16-byte boundary. Byte-address bits [3:2] of the first beat plus `bus_len` never exceed 4.
- R6: Beat k of a burst (k = `beat_cnt`, starting at 0) presents `bus_addr` = slot address + 4·k.
- R7: A beat completes only on a cycle where `bus_req` and `bus_ready` are both high. While `bus_ready` is low, `beat_cnt` and `bus_addr` hold.
- R8: A burst in progress is never pre-empted. `grant_id` stays constant from the first beat to the last, even when a higher-ranked slot is loaded meanwhile.
- R9: After the last beat, the granted slot's address advances by 4·`bus_len` bytes and its count drops by `bus_len`. `bus_req` is then low for exactly one arbitration cycle before the next burst starts.
- R10: `bus_write` equals the stored direction of the granted slot while `bus_req` is high, and is low otherwise.
- R11: A slot with a zero count is never granted. With no slot pending, `bus_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 4 | Per-slot load strobe |
| ld_addr | input | 4×AW | Per-slot start byte address |
| ld_cnt | input | 4×CW | Per-slot word count |
| ld_dir | input | 4 | Per-slot direction (1 = write to memory) |
| bus_req | output | 1 | Burst in progress, beat valid |
| bus_addr | output | AW | Byte address of the current beat |
| bus_write | output | 1 | Direction of the current burst |
| bus_len | output | LW | Length of the current burst in words |
| bus_ready | input | 1 | Beat accepted by the bus |
| grant_id | output | 2 | Slot that owns the current burst |
| beat_cnt | output | LW | Beats completed in the current burst |
| pending | output | 4 | Per-slot nonzero remaining count |

## Verification
Directed patterns cover three cases. The first is a start address at the last word of a 16-byte line, which separates boundary clipping from the four-word cap (lengths 1, 4, 1). The second loads all four slots at once, which exposes any error in the rank order. The third reloads the granted slot and a higher-ranked slot during a burst with `bus_ready` stalling, which separates ignored loads and pre-emption from correct holding. Constrained random loads then combine short counts, random line offsets, random directions and a ready line that drops about a third of the time. A cycle-level model in the bench compares grant, length, address, beat and direction on every cycle, so off-by-one errors in the boundary or in the idle gap show up.

// File: rtl/dma_burst_arb.sv
module dma_burst_arb #(
  parameter int AW   = 32,
  parameter int CW   = 12,
  parameter int MAXB = 4,
  parameter int BNDW = 4,
  parameter int LW   = $clog2(MAXB + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           ld_en,
  input  logic [3:0][AW-1:0]   ld_addr,
  input  logic [3:0][CW-1:0]   ld_cnt,
  input  logic [3:0]           ld_dir,
  output logic                 bus_req,
  output logic [AW-1:0]        bus_addr,
  output logic                 bus_write,
  output logic [LW-1:0]        bus_len,
  input  logic                 bus_ready,
  output logic [1:0]           grant_id,
  output logic [LW-1:0]        beat_cnt,
  output logic [3:0]           pending
);
  localparam int NR = 4;
  localparam int WA = AW - 2;
  localparam int BB = $clog2(BNDW);

  logic [WA-1:0] waddr [NR];
  logic [CW-1:0] cnt   [NR];
  logic [NR-1:0] dir;
  logic          busy;
  logic [1:0]    gid;
  logic [LW-1:0] len, beat;

  logic          found;
  logic [1:0]    sel;
  logic [CW-1:0] to_bnd, lim;
  logic          last;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NR - 1; i >= 0; i--)
      if (cnt[i] != '0) begin
        found = 1'b1;
        sel   = 2'(i);
      end
  end

  always_comb begin
    to_bnd = CW'(BNDW) - CW'(waddr[sel][BB-1:0]);
    lim    = cnt[sel];
    if (lim > CW'(MAXB)) lim = CW'(MAXB);
    if (lim > to_bnd)    lim = to_bnd;
  end

  assign last = (beat == len - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      gid  <= '0;
      len  <= '0;
      beat <= '0;
      dir  <= '0;
      for (int i = 0; i < NR; i++) begin
        waddr[i] <= '0;
        cnt[i]   <= '0;
      end
    end else begin
      if (!busy) begin
        if (found) begin
          busy <= 1'b1;
          gid  <= sel;
          len  <= LW'(lim);
          beat <= '0;
        end
      end else if (bus_ready) begin
        if (last) begin
          busy       <= 1'b0;
          beat       <= '0;
          waddr[gid] <= waddr[gid] + WA'(len);
          cnt[gid]   <= cnt[gid] - CW'(len);
        end else begin
          beat <= beat + LW'(1);
        end
      end
      for (int i = 0; i < NR; i++)
        if (ld_en[i] && cnt[i] == '0) begin
          waddr[i] <= ld_addr[i][AW-1:2];
          cnt[i]   <= ld_cnt[i];
          dir[i]   <= ld_dir[i];
        end
    end
  end

  assign bus_req   = busy;
  assign bus_addr  = {waddr[gid] + WA'(beat), 2'b00};
  assign bus_write = busy & dir[gid];
  assign bus_len   = busy ? len : '0;
  assign grant_id  = gid;
  assign beat_cnt  = beat;

  for (genvar g = 0; g < NR; g++) begin : g_pend
    assign pending[g] = (cnt[g] != '0);
  end

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_len >= LW'(1) && int'(bus_len) <= MAXB));

  // R5
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (int'(waddr[gid][BB-1:0]) + int'(bus_len) <= BNDW));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(beat_cnt) && $stable(bus_addr)));

  // R8
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_ready && beat_cnt == bus_len - LW'(1))) |=> (bus_req && $stable(grant_id)));

  // R9
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready && beat_cnt == bus_len - LW'(1)) |=> !bus_req);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == 4'b0) |=> !bus_req);
endmodule

// File: tb/dma_burst_arb_tb.sv
module dma_burst_arb_tb;
  localparam int CYC = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       ld_en = '0;
  logic [3:0][31:0] ld_addr = '0;
  logic [3:0][11:0] ld_cnt = '0;
  logic [3:0]       ld_dir = '0;
  logic             bus_ready = 1'b0;
  logic             bus_req, bus_write;
  logic [31:0]      bus_addr;
  logic [2:0]       bus_len, beat_cnt;
  logic [1:0]       grant_id;
  logic [3:0]       pending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  dma_burst_arb u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .ld_dir(ld_dir), .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_len(bus_len), .bus_ready(bus_ready), .grant_id(grant_id),
    .beat_cnt(beat_cnt), .pending(pending)
  );

  logic [29:0] m_wa [4];
  logic [11:0] m_cnt [4];
  logic [3:0]  m_dir;
  logic        m_busy;
  logic [1:0]  m_gid;
  logic [2:0]  m_len, m_beat;

  function automatic logic [2:0] exp_len(input logic [11:0] c, input logic [29:0] wa);
    int v;
    v = int'(c);
    if (v > 4) v = 4;
    if (v > 4 - int'(wa[1:0])) v = 4 - int'(wa[1:0]);
    return 3'(v);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_wa[i] = '0; m_cnt[i] = '0; end
    m_dir = '0; m_busy = 0; m_gid = '0; m_len = '0; m_beat = '0;
  endtask

  task automatic step_model();
    logic [29:0] n_wa [4];
    logic [11:0] n_cnt [4];
    for (int i = 0; i < 4; i++) begin n_wa[i] = m_wa[i]; n_cnt[i] = m_cnt[i]; end
    if (!m_busy) begin
      for (int i = 3; i >= 0; i--)
        if (m_cnt[i] != 0) begin
          m_gid = 2'(i);
        end
      if (m_cnt[0] != 0 || m_cnt[1] != 0 || m_cnt[2] != 0 || m_cnt[3] != 0) begin
        m_busy = 1; m_len = exp_len(m_cnt[m_gid], m_wa[m_gid]); m_beat = 0;
      end
    end else if (bus_ready) begin
      if (m_beat == m_len - 1) begin
        m_busy = 0; m_beat = 0;
        n_wa[m_gid]  = m_wa[m_gid] + 30'(m_len);
        n_cnt[m_gid] = m_cnt[m_gid] - 12'(m_len);
      end else m_beat = m_beat + 1;
    end
    for (int i = 0; i < 4; i++)
      if (ld_en[i] && m_cnt[i] == 0) begin
        n_wa[i] = ld_addr[i][31:2]; n_cnt[i] = ld_cnt[i]; m_dir[i] = ld_dir[i];
      end
    for (int i = 0; i < 4; i++) begin m_wa[i] = n_wa[i]; m_cnt[i] = n_cnt[i]; end
  endtask

  task automatic compare_all();
    logic [3:0] ep;
    for (int i = 0; i < 4; i++) ep[i] = (m_cnt[i] != 0);
    chk("R2 pending", 32'(pending), 32'(ep));
    chk("R9 R11 bus_req", 32'(bus_req), 32'(m_busy));
    if (m_busy) begin
      chk("R3 R8 grant_id", 32'(grant_id), 32'(m_gid));
      chk("R4 bus_len", 32'(bus_len), 32'(m_len));
      chk("R7 beat_cnt", 32'(beat_cnt), 32'(m_beat));
      chk("R6 bus_addr", bus_addr, {m_wa[m_gid] + 30'(m_beat), 2'b00});
      chk("R10 bus_write", 32'(bus_write), 32'(m_dir[m_gid]));
      chk("R5 boundary", 32'(int'(bus_addr[3:2]) + int'(bus_len) - int'(beat_cnt) <= 4), 32'd1);
    end else begin
      chk("R10 bus_write idle", 32'(bus_write), 32'd0);
    end
  endtask

  task automatic tick();
    step_model();
    @(negedge clk);
    compare_all();
    ld_en = '0;
  endtask

  task automatic load(input int i, input logic [31:0] a, input logic [11:0] c, input logic d);
    ld_en[i] = 1'b1; ld_addr[i] = a; ld_cnt[i] = c; ld_dir[i] = d;
  endtask

  task automatic drain(input int maxc);
    for (int k = 0; k < maxc; k++) begin
      if (!bus_req && pending == 0 && !m_busy) break;
      tick();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CYC * 150000);
    errors++;
    $display("FAIL watchdog (R1..) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bus_req", 32'(bus_req), 32'd0);
    chk("R1 pending", 32'(pending), 32'd0);
    chk("R1 beat_cnt", 32'(beat_cnt), 32'd0);
    rst_n = 1'b1;

    // R4 R5: start at last word of a line, 6 words -> 1,4,1
    bus_ready = 1'b1;
    load(2, 32'h0000_001C, 12'd6, 1'b0);
    tick();
    tick();
    chk("R4 first len", 32'(bus_len), 32'd1);
    drain(100);

    // R3: all four loaded at once, slot 0 wins
    for (int i = 0; i < 4; i++) load(i, 32'h100 * (i + 1), 12'd3, i[0]);
    tick();
    tick();
    chk("R3 top rank", 32'(grant_id), 32'd0);
    drain(200);

    // R2 R8: reload during stalled burst
    bus_ready = 1'b0;
    load(3, 32'h0000_0200, 12'd8, 1'b1);
    tick();
    tick();
    load(3, 32'h0000_0F00, 12'd2, 1'b0);
    load(0, 32'h0000_0400, 12'd2, 1'b1);
    tick();
    tick();
    chk("R8 held grant", 32'(grant_id), 32'd3);
    chk("R2 ignored reload addr", bus_addr, 32'h0000_0200);
    bus_ready = 1'b1;
    drain(200);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bus_ready = ($urandom_range(0, 2) != 0);
      for (int i = 0; i < 4; i++)
        if ($urandom_range(0, 9) == 0)
          load(i, $urandom(), 12'($urandom_range(0, 9)), 1'($urandom_range(0, 1)));
      tick();
    end
    bus_ready = 1'b1;
    drain(500);
    finish_run();
  end
endmodule